// File: doc/BRIEF.md
# Conversion Result Stack Serializer

This block sits between a sampling converter and the transmit side of a two-wire serial target. While conversions run, each finished 12-bit result is pushed onto a small last-in first-out store of four words. When the bus controller later reads the device, the block presents the stored results one byte at a time. Each word goes out as two bytes: first a byte of four zero bits followed by the top four result bits, then a byte with the lower eight result bits.

A read-byte request tells the block that the transmit path has consumed the byte now on its output. The block then moves to the other half of the word. After the lower half has been taken, it moves to the next stored word. A mode input selects between the slower bus speeds, where up to four words are read in one transfer, and the high-speed mode, where only one word is valid per transfer. A clear input empties the store when the command decoder rejects a command. Bus signalling, acknowledge generation and the converter itself lie outside the block.

Top module: `result_stack_serializer`

## Requirements
- R1: After reset the stored-word count is 0 and the transmit byte is 0xFF.
- R2: Each push with the store not full stores the word and raises the count by one, up to a maximum of 4.
- R3: A push into a full store discards the oldest entry and keeps the four most recent words. The count stays at 4.
- R4: A word is sent high byte first. The high byte is 4'b0000 followed by bits 11..8. The low byte is bits 7..0. Each accepted read request switches the half that is shown.
- R5: In standard/fast mode (hs_mode_i = 0), words come out newest first. A word is removed only when its low byte is taken, which lowers the count by one.
- R6: With the store empty, the transmit byte is 0xFF, and read requests leave the count at 0.
- R7: In high-speed mode (hs_mode_i = 1), taking the low byte of the top word empties the whole store. All later bytes are 0xFF.
- R8: The clear input sets the count to 0, whatever else is requested in that cycle.
- R9: A push returns the byte select to the high byte, so the new top word is shown from its high byte.
- R10: Priority is clear, then push, then read. A read request in the same cycle as a push is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| push_i | input | 1 | Store a new conversion result |
| push_data_i | input | 12 | Conversion result to store |
| clear_i | input | 1 | Empty the store |
| rd_byte_i | input | 1 | The transmit path has taken the current byte |
| hs_mode_i | input | 1 | 1 = high-speed single-word reads, 0 = standard/fast |
| tx_byte_o | output | 8 | Byte to transmit next |
| count_o | output | 3 | Number of stored words |

## Verification
The main vector walk fills the store past capacity with distinct words and then drains it byte by byte. The last byte before the store runs empty shows whether the oldest word, and not some other entry, was dropped. The words use different top nibbles and low bytes, so a swapped half, a missing zero pad or a wrong pop order all produce a different byte. High-speed reads are checked after a high byte has already been taken, which separates the drain-on-low-byte rule from a drain on any read. A push and a read in the same cycle, and a clear with a push, exercise the priority order when the byte select sits on the low half.

// File: rtl/rss_pkg.sv
package rss_pkg;
  localparam int RES_W  = 12;
  localparam int BYTE_W = 8;
  localparam int PAD_W  = 2 * BYTE_W - RES_W;

  typedef enum logic { SEL_HI = 1'b0, SEL_LO = 1'b1 } half_e;

  // upper byte: zero pad followed by the top bits of the result
  function automatic logic [BYTE_W-1:0] hi_part(input logic [RES_W-1:0] w);
    return {{PAD_W{1'b0}}, w[RES_W-1:BYTE_W]};
  endfunction

  function automatic logic [BYTE_W-1:0] lo_part(input logic [RES_W-1:0] w);
    return w[BYTE_W-1:0];
  endfunction
endpackage

// File: rtl/rss_store.sv
module rss_store #(
  parameter int DEPTH = 4,
  parameter int W     = 12,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic          drop_all_i,
  input  logic [W-1:0]  din_i,
  output logic [W-1:0]  top_o,
  output logic [CW-1:0] count_o
);
  logic [W-1:0]  mem [DEPTH];
  logic [CW-1:0] count_q;
  logic          full;
  logic [CW-1:0] top_cnt;
  logic [IW-1:0] top_idx;

  assign full    = (count_q == CW'(DEPTH));
  assign top_cnt = count_q - CW'(1);
  assign top_idx = top_cnt[IW-1:0];
  assign top_o   = mem[top_idx];
  assign count_o = count_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                count_q <= '0;
    else if (clr_i)            count_q <= '0;
    else if (push_i && !full)  count_q <= count_q + CW'(1);
    else if (push_i)           count_q <= count_q;
    else if (drop_all_i)       count_q <= '0;
    else if (pop_i && count_q != '0) count_q <= count_q - CW'(1);
  end

  // storage carries no reset; validity is tracked by count_q
  always_ff @(posedge clk) begin
    if (!clr_i && push_i) begin
      if (full) begin
        for (int i = 0; i < DEPTH - 1; i++) mem[i] <= mem[i+1];
        mem[DEPTH-1] <= din_i;
      end else begin
        mem[count_q[IW-1:0]] <= din_i;
      end
    end
  end

  p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CW'(DEPTH));
  p_full_push_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !clr_i && full) |=> (count_q == CW'(DEPTH)));
  p_pop_dec_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !push_i && !clr_i && !drop_all_i && count_q != '0)
      |=> (count_q == $past(count_q) - CW'(1)));
  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (count_q == '0));
endmodule

// File: rtl/rss_bytesel.sv
module rss_bytesel
  import rss_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  restart_i,
  input  logic  take_i,
  output half_e sel_o,
  output logic  word_done_o
);
  half_e sel_q;

  assign sel_o       = sel_q;
  assign word_done_o = take_i && (sel_q == SEL_LO);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         sel_q <= SEL_HI;
    else if (restart_i) sel_q <= SEL_HI;
    else if (take_i)    sel_q <= (sel_q == SEL_HI) ? SEL_LO : SEL_HI;
  end

  p_take_flips_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && !restart_i) |=> (sel_q != $past(sel_q)));
  p_restart_hi_r9: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> (sel_q == SEL_HI));
endmodule

// File: rtl/result_stack_serializer.sv
module result_stack_serializer
  import rss_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_i,
  input  logic [RES_W-1:0]  push_data_i,
  input  logic              clear_i,
  input  logic              rd_byte_i,
  input  logic              hs_mode_i,
  output logic [BYTE_W-1:0] tx_byte_o,
  output logic [CW-1:0]     count_o
);
  logic [RES_W-1:0] top_word;
  logic [CW-1:0]    count;
  logic             empty;
  logic             take;       // accepted read request
  logic             word_done;  // low byte of the top word consumed
  logic             pop_one;
  logic             drop_all;
  logic             restart;
  half_e            sel;

  assign empty    = (count == '0);
  assign take     = rd_byte_i && !push_i && !clear_i && !empty;
  assign restart  = clear_i || push_i;
  assign pop_one  = word_done && !hs_mode_i;
  assign drop_all = word_done && hs_mode_i;

  rss_store #(.DEPTH(DEPTH), .W(RES_W)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (clear_i),
    .push_i     (push_i),
    .pop_i      (pop_one),
    .drop_all_i (drop_all),
    .din_i      (push_data_i),
    .top_o      (top_word),
    .count_o    (count)
  );

  rss_bytesel u_sel (
    .clk         (clk),
    .rst_n       (rst_n),
    .restart_i   (restart),
    .take_i      (take),
    .sel_o       (sel),
    .word_done_o (word_done)
  );

  always_comb begin
    if (empty)              tx_byte_o = '1;
    else if (sel == SEL_HI) tx_byte_o = hi_part(top_word);
    else                    tx_byte_o = lo_part(top_word);
  end

  assign count_o = count;

  p_empty_ff_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (count_o == '0) |-> (tx_byte_o == '1));
  p_hs_drain_r7: assert property (@(posedge clk) disable iff (!rst_n)
    drop_all |=> (count_o == '0));
  p_pad_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty && sel == SEL_HI) |-> (tx_byte_o[BYTE_W-1 -: PAD_W] == '0));
  p_push_blocks_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !clear_i && count_o != CW'(DEPTH)) |=> (count_o == $past(count_o) + CW'(1)));
endmodule

// File: tb/result_stack_serializer_bench.sv
module result_stack_serializer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 26;
  // {op[1:0], data[11:0], hs, exp_tx[7:0], exp_cnt[2:0], req[3:0]}
  // op: 0 idle, 1 push, 2 read byte, 3 clear
  localparam logic [29:0] VEC [NV] = '{
    {2'd1, 12'h123, 1'b0, 8'h01, 3'd1, 4'd2},  // R2
    {2'd1, 12'h456, 1'b0, 8'h04, 3'd2, 4'd2},  // R2
    {2'd1, 12'h789, 1'b0, 8'h07, 3'd3, 4'd2},  // R2
    {2'd1, 12'hABC, 1'b0, 8'h0A, 3'd4, 4'd2},  // R2
    {2'd1, 12'hDEF, 1'b0, 8'h0D, 3'd4, 4'd3},  // R3 full push
    {2'd2, 12'h000, 1'b0, 8'hEF, 3'd4, 4'd4},  // R4 low half
    {2'd2, 12'h000, 1'b0, 8'h0A, 3'd3, 4'd5},  // R5 pop
    {2'd2, 12'h000, 1'b0, 8'hBC, 3'd3, 4'd4},
    {2'd2, 12'h000, 1'b0, 8'h07, 3'd2, 4'd5},
    {2'd2, 12'h000, 1'b0, 8'h89, 3'd2, 4'd4},
    {2'd2, 12'h000, 1'b0, 8'h04, 3'd1, 4'd5},
    {2'd2, 12'h000, 1'b0, 8'h56, 3'd1, 4'd4},
    {2'd2, 12'h000, 1'b0, 8'hFF, 3'd0, 4'd3},  // R3: 0x123 was dropped
    {2'd2, 12'h000, 1'b0, 8'hFF, 3'd0, 4'd6},  // R6 empty read
    {2'd1, 12'hF0E, 1'b0, 8'h0F, 3'd1, 4'd4},
    {2'd1, 12'h0A5, 1'b0, 8'h00, 3'd2, 4'd4},
    {2'd2, 12'h000, 1'b0, 8'hA5, 3'd2, 4'd4},
    {2'd1, 12'h3C7, 1'b0, 8'h03, 3'd3, 4'd9},  // R9 push restarts at high
    {2'd2, 12'h000, 1'b1, 8'hC7, 3'd3, 4'd7},  // R7 high byte no drain
    {2'd2, 12'h000, 1'b1, 8'hFF, 3'd0, 4'd7},  // R7 drain
    {2'd2, 12'h000, 1'b1, 8'hFF, 3'd0, 4'd7},
    {2'd1, 12'h800, 1'b0, 8'h08, 3'd1, 4'd2},
    {2'd1, 12'h001, 1'b0, 8'h00, 3'd2, 4'd2},
    {2'd2, 12'h000, 1'b0, 8'h01, 3'd2, 4'd4},
    {2'd3, 12'h000, 1'b0, 8'hFF, 3'd0, 4'd8},  // R8 clear
    {2'd1, 12'h7FF, 1'b0, 8'h07, 3'd1, 4'd8}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic push_i = 1'b0, clear_i = 1'b0, rd_byte_i = 1'b0, hs_mode_i = 1'b0;
  logic [11:0] push_data_i = '0;
  logic [7:0] tx_byte_o;
  logic [2:0] count_o;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  result_stack_serializer u_result_stack_serializer (
    .clk(clk), .rst_n(rst_n), .push_i(push_i), .push_data_i(push_data_i),
    .clear_i(clear_i), .rd_byte_i(rd_byte_i), .hs_mode_i(hs_mode_i),
    .tx_byte_o(tx_byte_o), .count_o(count_o)
  );

  task automatic check(input string tag, input logic [7:0] etx, input logic [2:0] ecnt);
    checks++;
    if (tx_byte_o !== etx || count_o !== ecnt) begin
      failures++;
      $display("FAIL %s: tx=%h cnt=%0d expected tx=%h cnt=%0d", tag, tx_byte_o, count_o, etx, ecnt);
    end
  endtask

  // inputs applied at a falling edge, released after the rising edge
  task automatic cycle(input logic p, input logic r, input logic c, input logic h, input logic [11:0] d);
    push_i = p; rd_byte_i = r; clear_i = c; hs_mode_i = h; push_data_i = d;
    @(posedge clk);
    #(CLK_PERIOD/4);
    push_i = 1'b0; rd_byte_i = 1'b0; clear_i = 1'b0; push_data_i = '0;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    failures++;
    $display("FAIL watchdog: tx=%h cnt=%0d expected completion", tx_byte_o, count_o);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", 8'hFF, 3'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", 8'hFF, 3'd0);

    for (int i = 0; i < NV; i++) begin
      logic [1:0] op;
      op = VEC[i][29:28];
      cycle(op == 2'd1, op == 2'd2, op == 2'd3, VEC[i][15], VEC[i][27:16]);
      check($sformatf("R%0d vector %0d", VEC[i][3:0], i), VEC[i][14:7], VEC[i][6:4]);
    end

    // R10: push and read together with the select on the low half
    cycle(1'b1, 1'b0, 1'b0, 1'b0, 12'h2B4);
    cycle(1'b0, 1'b1, 1'b0, 1'b0, 12'h000);
    check("R10 setup low half", 8'hB4, 3'd2);
    cycle(1'b1, 1'b1, 1'b0, 1'b0, 12'h9E1);
    check("R10 read ignored on push", 8'h09, 3'd3);
    cycle(1'b0, 1'b1, 1'b0, 1'b0, 12'h000);
    check("R10 read resumes", 8'hE1, 3'd3);

    // R8: clear wins over a simultaneous push
    cycle(1'b1, 1'b0, 1'b1, 1'b0, 12'h555);
    check("R8 clear beats push", 8'hFF, 3'd0);
    cycle(1'b0, 1'b1, 1'b0, 1'b0, 12'h000);
    check("R6 read after clear", 8'hFF, 3'd0);

    // R1: reset in mid-stream
    cycle(1'b1, 1'b0, 1'b0, 1'b0, 12'h6D2);
    rst_n = 1'b0;
    #1;
    check("R1 async reset", 8'hFF, 3'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    finish_run();
  end
endmodule